// File: doc/BRIEF.md
# Bus Handshake Response Timeout Monitor

This block watches the master side of an asynchronous two-wire handshake. It covers two channels. On the address channel the master drives an address-sync line and the slave answers on an address-acknowledge line. On the data channel the master drives a data-sync line and the slave answers on a data-acknowledge line. Every change of a master line, in either direction, opens a response window. The window closes when the slave line reaches the same level. If the slave has not followed when the window runs out, the block raises a sticky error bit for that channel. The window is made deliberately longer than the bus minimum. Slow broadcast responders and acknowledge releases that ripple back through a chain of slaves therefore finish inside it.

The slave inputs are asynchronous, so they pass through a synchroniser of `SYNC_STAGES` flops. The master lines are local, but they go through a delay of the same length, so that both sides of each comparison are aligned and the window is measured in raw clock edges. The data acknowledge is held back by `DK_DELAY` further cycles before it is presented as a qualified acknowledge. The 3-bit slave status is captured when that qualified edge appears, which gives the status lines a setup window after the acknowledge moves. Software clears the error bits with a one-cycle strobe.

Top module: `hs_timeout_mon`

## Requirements
- R1: While reset is asserted and after it is released, `tmo_err_o`, `dk_qual_o` and `ss_cap_o` are all zero.
- R2: Each change of `as_i` opens the address-channel window, and each change of `ds_i` opens the data-channel window, on both rising and falling edges. A new change on the same line closes the open window of that channel and starts a fresh one.
- R3: Let edge k be the clock edge that first samples a master change. The response succeeds if the slave line is sampled at the new master level on at least one of the edges k+1 to k+`TMO_LIMIT`; an answer sampled exactly at edge k+`TMO_LIMIT` is a success. Otherwise the error bit of that channel is set by edge k+`TMO_LIMIT`+`SYNC_STAGES`. Bit 0 is the address channel (`as_i`/`ak_i`) and bit 1 is the data channel (`ds_i`/`dk_i`).
- R4: Once set, an error bit stays at 1 until it is cleared.
- R5: When `tmo_clr_i` is sampled high at an edge, both error bits are cleared at that edge. A bit whose timeout ends at that same edge stays set.
- R6: After edge n, `dk_qual_o` equals `dk_i` as sampled at edge n-`SYNC_STAGES`-`DK_DELAY`+1.
- R7: At an edge where `dk_qual_o` changes, `ss_cap_o` loads `ss_i` as sampled at edge n-`SYNC_STAGES`. At every other edge it holds its value, even if `ss_i` changes.
- R8: A change of a slave line while no window is open on its channel has no effect on `tmo_err_o`.
- R9: The two channels time out independently. A timeout on one channel never sets the error bit of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_i | input | 1 | Master address-sync line (1 = asserted) |
| ds_i | input | 1 | Master data-sync line (1 = asserted) |
| ak_i | input | 1 | Slave address acknowledge, asynchronous |
| dk_i | input | 1 | Slave data acknowledge, asynchronous |
| ss_i | input | SS_W | Slave status lines, asynchronous |
| tmo_clr_i | input | 1 | One-cycle strobe that clears the error bits |
| dk_qual_o | output | 1 | Data acknowledge after synchronisation and qualification delay |
| ss_cap_o | output | SS_W | Status captured on each qualified acknowledge edge |
| tmo_err_o | output | 2 | Sticky timeout bits: bit 0 address channel, bit 1 data channel |

## Verification
The bench builds the monitor with `TMO_LIMIT` = 16, `DK_DELAY` = 4, `SYNC_STAGES` = 2 and `SS_W` = 3. The short window makes the boundary cases cheap to reach: an answer exactly at the limit, one edge past it, and a clear strobe that lands on the same edge as a timeout. A four-cycle qualification delay keeps the acknowledge-to-status timing visible at an exact cycle. Changing a master line twice inside one window exercises the restart of the window.

// File: rtl/hto_pkg.sv
package hto_pkg;

    localparam int NUM_CH  = 2;
    localparam int CH_ADDR = 0;
    localparam int CH_DATA = 1;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_WAIT = 1'b1
    } hs_state_e;

endpackage

// File: rtl/hto_sync.sv
// Flop chain used both as a synchroniser for the slave lines and as an
// equal-length alignment delay for the master lines.
module hto_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);

    localparam int BITS = W * STAGES;

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = BITS'({chain_q, din_i});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout_o = chain_q[STAGES-1];

endmodule

// File: rtl/hto_resp_timer.sv
// One channel: opens a window on every master edge and closes it when the
// slave level matches. Fires once if the window runs out.
module hto_resp_timer
    import hto_pkg::*;
#(
    parameter int LIMIT = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mst_i,
    input  logic slv_i,
    output logic start_o,
    output logic busy_o,
    output logic fire_o
);

    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        hs_state_e       st;
        logic            lvl;
        logic [CW-1:0]   cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic start_c, fire_c;

    always_comb begin
        tmr_d   = tmr_q;
        start_c = (mst_i != tmr_q.lvl);
        fire_c  = 1'b0;
        if (start_c) begin
            tmr_d.lvl = mst_i;
            tmr_d.st  = HS_WAIT;
            tmr_d.cnt = '0;
        end else if (tmr_q.st == HS_WAIT) begin
            if (slv_i == tmr_q.lvl) begin
                tmr_d.st = HS_IDLE;
            end else if (tmr_q.cnt == LAST) begin
                fire_c   = 1'b1;
                tmr_d.st = HS_IDLE;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{st: HS_IDLE, lvl: 1'b0, cnt: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign start_o = start_c;
    assign fire_o  = fire_c;
    assign busy_o  = (tmr_q.st == HS_WAIT);

endmodule

// File: rtl/hto_dk_qual.sv
// Delays the synchronised data acknowledge and captures status on the
// delayed edge.
module hto_dk_qual #(
    parameter int DLY = 4,
    parameter int SSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dk_s_i,
    input  logic [SSW-1:0] ss_s_i,
    output logic           dk_qual_o,
    output logic [SSW-1:0] ss_cap_o
);

    typedef struct packed {
        logic [DLY-1:0] line;
        logic [SSW-1:0] cap;
    } dq_t;

    dq_t dq_d, dq_q;

    always_comb begin
        dq_d      = dq_q;
        dq_d.line = DLY'({dq_q.line, dk_s_i});
        if (dq_d.line[DLY-1] != dq_q.line[DLY-1]) begin
            dq_d.cap = ss_s_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_q <= '0;
        end else begin
            dq_q <= dq_d;
        end
    end

    assign dk_qual_o = dq_q.line[DLY-1];
    assign ss_cap_o  = dq_q.cap;

endmodule

// File: rtl/hs_timeout_mon.sv
module hs_timeout_mon
    import hto_pkg::*;
#(
    parameter int TMO_LIMIT   = 300,
    parameter int DK_DELAY    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int SS_W        = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            as_i,
    input  logic            ds_i,
    input  logic            ak_i,
    input  logic            dk_i,
    input  logic [SS_W-1:0] ss_i,
    input  logic            tmo_clr_i,
    output logic            dk_qual_o,
    output logic [SS_W-1:0] ss_cap_o,
    output logic [1:0]      tmo_err_o
);

    localparam int SLV_W = NUM_CH + SS_W;

    logic [SLV_W-1:0]  slv_s;
    logic [NUM_CH-1:0] mst_al;
    logic [NUM_CH-1:0] tmr_start, tmr_busy, tmr_fire;
    logic [NUM_CH-1:0] err_d, err_q;

    hto_sync #(.W(SLV_W), .STAGES(SYNC_STAGES)) u_sync_slv (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  ({ss_i, dk_i, ak_i}),
        .dout_o (slv_s)
    );

    hto_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_align_mst (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  ({ds_i, as_i}),
        .dout_o (mst_al)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        hto_resp_timer #(.LIMIT(TMO_LIMIT)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .mst_i   (mst_al[c]),
            .slv_i   (slv_s[c]),
            .start_o (tmr_start[c]),
            .busy_o  (tmr_busy[c]),
            .fire_o  (tmr_fire[c])
        );
    end

    hto_dk_qual #(.DLY(DK_DELAY), .SSW(SS_W)) u_dkq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dk_s_i    (slv_s[CH_DATA]),
        .ss_s_i    (slv_s[SLV_W-1:NUM_CH]),
        .dk_qual_o (dk_qual_o),
        .ss_cap_o  (ss_cap_o)
    );

    // Sticky error: a fresh timeout wins over a clear on the same edge.
    always_comb begin
        err_d = tmr_fire | (err_q & {NUM_CH{~tmo_clr_i}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    assign tmo_err_o = err_q;

endmodule

// File: rtl/hto_checker.sv
module hto_checker #(
    parameter int LIMIT = 300,
    parameter int SSW   = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tmo_clr_i,
    input logic [1:0]     tmo_err_o,
    input logic           dk_qual_o,
    input logic [SSW-1:0] ss_cap_o,
    input logic [1:0]     start,
    input logic [1:0]     busy,
    input logic [1:0]     fire
);

    localparam int SW = $clog2(LIMIT + 2);
    localparam logic [SW-1:0] SAT = SW'(LIMIT + 1);

    for (genvar c = 0; c < 2; c++) begin : g_chk
        logic [SW-1:0] since_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                since_q <= '0;
            end else if (start[c]) begin
                since_q <= '0;
            end else if (since_q != SAT) begin
                since_q <= since_q + 1'b1;
            end
        end

        assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (tmo_err_o[c] && !tmo_clr_i) |=> tmo_err_o[c]);

        assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (tmo_clr_i && !fire[c]) |=> !tmo_err_o[c]);

        assert_no_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tmo_err_o[c]) |-> (since_q >= SW'(LIMIT)));

        assert_open_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tmo_err_o[c]) |-> $past(busy[c]));
    end

    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ss_cap_o) |-> !$stable(dk_qual_o));

endmodule

bind hs_timeout_mon hto_checker #(.LIMIT(TMO_LIMIT), .SSW(SS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmo_clr_i (tmo_clr_i),
    .tmo_err_o (tmo_err_o),
    .dk_qual_o (dk_qual_o),
    .ss_cap_o  (ss_cap_o),
    .start     (tmr_start),
    .busy      (tmr_busy),
    .fire      (tmr_fire)
);

// File: tb/tb_hs_timeout_mon.sv
`timescale 1ns/1ps
module tb_hs_timeout_mon;

    localparam int LIM  = 16;
    localparam int DLY  = 4;
    localparam int SYN  = 2;
    localparam int SSW  = 3;
    localparam int HMAX = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic as_i = 0, ds_i = 0, ak_i = 0, dk_i = 0, tmo_clr_i = 0;
    logic [SSW-1:0] ss_i = '0;
    logic dk_qual_o;
    logic [SSW-1:0] ss_cap_o;
    logic [1:0] tmo_err_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    hs_timeout_mon #(.TMO_LIMIT(LIM), .DK_DELAY(DLY), .SYNC_STAGES(SYN), .SS_W(SSW)) dut (
        .clk(clk), .rst_n(rst_n), .as_i(as_i), .ds_i(ds_i), .ak_i(ak_i), .dk_i(dk_i),
        .ss_i(ss_i), .tmo_clr_i(tmo_clr_i), .dk_qual_o(dk_qual_o), .ss_cap_o(ss_cap_o),
        .tmo_err_o(tmo_err_o)
    );

    // ---------------- behavioural reference ----------------
    logic h_m [2][HMAX];
    logic h_s [2][HMAX];
    logic h_dk [HMAX];
    logic [SSW-1:0] h_ss [HMAX];
    logic h_clr [HMAX];
    int  n = 0;
    bit  pend [2];
    int  start_e [2];
    logic lvl [2];
    int  fire_at [2];
    logic [1:0] e_err = '0;
    logic e_q = 0;
    logic [SSW-1:0] e_cap = '0;

    function automatic logic m_at(int c, int i);
        return (i < 0) ? 1'b0 : h_m[c][i];
    endfunction
    function automatic logic dk_at(int i);
        return (i < 0) ? 1'b0 : h_dk[i];
    endfunction
    function automatic logic [SSW-1:0] ss_at(int i);
        return (i < 0) ? '0 : h_ss[i];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            n = 0; e_err = '0; e_q = 0; e_cap = '0;
            for (int c = 0; c < 2; c++) begin pend[c] = 0; fire_at[c] = -1; lvl[c] = 0; start_e[c] = 0; end
        end else begin
            h_m[0][n] = as_i; h_m[1][n] = ds_i;
            h_s[0][n] = ak_i; h_s[1][n] = dk_i;
            h_dk[n] = dk_i; h_ss[n] = ss_i; h_clr[n] = tmo_clr_i;
            for (int c = 0; c < 2; c++) begin
                if (m_at(c, n) != m_at(c, n-1)) begin
                    pend[c] = 1; start_e[c] = n; lvl[c] = m_at(c, n);
                end else if (pend[c]) begin
                    if (h_s[c][n] == lvl[c]) pend[c] = 0;
                    else if (n == start_e[c] + LIM) begin pend[c] = 0; fire_at[c] = n + SYN; end
                end
                e_err[c] = (fire_at[c] == n) | (e_err[c] & ~h_clr[n]);
            end
            begin
                logic nq;
                nq = dk_at(n - DLY - SYN + 1);
                if (nq != e_q) e_cap = ss_at(n - SYN);
                e_q = nq;
            end
            n++;
        end
    end

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison with the reference, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(32'(tmo_err_o), 32'(e_err), "R3 timeout bits vs model");
            chk(32'(dk_qual_o), 32'(e_q), "R6 qualified ack vs model");
            chk(32'(ss_cap_o), 32'(e_cap), "R7 captured status vs model");
        end
    end

    task automatic wait_n(input int k);
        repeat (k) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        wait_n(3);
        chk(32'(tmo_err_o), 0, "R1 reset err");
        chk(32'(dk_qual_o), 0, "R1 reset qual");
        chk(32'(ss_cap_o), 0, "R1 reset cap");
        rst_n = 1'b1;
        wait_n(4);
        chk(32'(tmo_err_o), 0, "R1 after release");

        // R2/R3: prompt answer on the address channel
        as_i = 1; wait_n(3); ak_i = 1; wait_n(LIM + 6);
        chk(32'(tmo_err_o), 0, "R3 prompt response");

        // R3: release answered exactly at the limit (rippled release)
        as_i = 0; wait_n(LIM); ak_i = 0; wait_n(LIM + 6);
        chk(32'(tmo_err_o), 0, "R3 response at limit");

        // R3: one edge too late
        as_i = 1; wait_n(LIM + 1); ak_i = 1; wait_n(LIM + 6);
        chk(32'(tmo_err_o), 2'b01, "R3 late response sets bit0");

        // R4: sticky
        wait_n(20);
        chk(32'(tmo_err_o), 2'b01, "R4 bit stays set");

        // R5: clear
        tmo_clr_i = 1; wait_n(1); tmo_clr_i = 0; wait_n(1);
        chk(32'(tmo_err_o), 0, "R5 clear");

        // R9: data channel timeout, address bit untouched; R6/R7 capture
        ss_i = 3'd5; ds_i = 1; wait_n(LIM + 1); dk_i = 1; wait_n(LIM + 6);
        chk(32'(tmo_err_o), 2'b10, "R9 data channel only");
        chk(32'(ss_cap_o), 3'd5, "R7 status captured");
        ss_i = 3'd2; wait_n(6);
        chk(32'(ss_cap_o), 3'd5, "R7 hold without ack edge");
        tmo_clr_i = 1; wait_n(1); tmo_clr_i = 0; wait_n(1);

        // R6: exact qualification cycle on a falling acknowledge
        ds_i = 0; dk_i = 0; wait_n(SYN + DLY - 1);
        chk(32'(dk_qual_o), 1, "R6 not yet qualified");
        wait_n(1);
        chk(32'(dk_qual_o), 0, "R6 qualified edge");
        chk(32'(ss_cap_o), 3'd2, "R7 capture on falling edge");
        wait_n(LIM + 4);
        chk(32'(tmo_err_o), 0, "R3 data prompt release");

        // R5: clear lands on the timeout edge (edge k+LIM+SYN)
        as_i = 0; wait_n(LIM + SYN); tmo_clr_i = 1; wait_n(1); tmo_clr_i = 0; wait_n(2);
        chk(32'(tmo_err_o), 2'b01, "R5 fresh timeout beats clear");
        ak_i = 0; wait_n(4);
        tmo_clr_i = 1; wait_n(1); tmo_clr_i = 0; wait_n(1);
        chk(32'(tmo_err_o), 0, "R5 clear again");

        // R2: restart — master returns before slave answers
        ds_i = 1; wait_n(10); ds_i = 0; wait_n(LIM + 8);
        chk(32'(tmo_err_o), 0, "R2 restart closes first window");

        // R8: slave lines move with no open window
        ak_i = 1; wait_n(3); ak_i = 0; dk_i = 1; wait_n(3); dk_i = 0; wait_n(LIM + 8);
        chk(32'(tmo_err_o), 0, "R8 idle slave change ignored");

        // Both channels late together
        as_i = 1; ds_i = 1; wait_n(LIM + 8);
        chk(32'(tmo_err_o), 2'b11, "R9 both channels");
        ak_i = 1; dk_i = 1; wait_n(12);

        finish_run();
    end

endmodule